// File: doc/BRIEF.md
# Camera Frame Reformatter with Read and Frame-Start Strobes

This block sits between a pixel FIFO, filled by a camera controller, and a downstream processor port. Once readout is started it pulls 16-bit words from the FIFO whenever the FIFO reports data. It drops everything until it sees two zero words in a row. It then rewrites the ten-word controller header into a seven-word header, passes the pixels through and checks that a zero word closes the frame. Each FIFO read is a pulse of programmable width. The same pulse strobes the forwarded word into the downstream processor. A programmable-width frame-start pulse comes before the first forwarded word of every frame.

Frames repeat until an abort arrives. A readout timeout leaves a frame that has stalled, without stopping readout. A nine-bit status word reports where the block is and which errors the current frame has hit. A one-cycle interrupt pulse marks the end of every frame attempt, whether it completed, hit an end-of-frame error or timed out.

Top module: `cam_frame_reformat`

## Requirements
- R1: While reset is held and after it is released, `fifo_rd`, `dn_strobe`, `frame_start` and `frame_irq` are low and `status` is zero until readout is started.
- R2: While hunting, input words are read and discarded without any `dn_strobe` until two consecutive zero words arrive. A lone zero between nonzero words does not count as sync.
- R3: After sync, the first of the two mode words is dropped. The forwarded sequence is the second mode word, frame count high, frame count low, exposure high, exposure low, rows, cols, then the pixels in order.
- R4: The pixel count is rows × cols (the 7th and 8th words after sync) when `use_rc` is 1, and `pix_n` when it is 0. A count of zero goes straight to the end-of-frame check.
- R5: The word after the last pixel is compared with zero. In either case the block pulses `frame_irq` for one cycle and returns to hunting. `status[1]` (end-of-frame error) is set only when that word is nonzero.
- R6: `frame_start` goes high once per frame, on the read that completes the sync pair. It stays high for `fs_width` cycles, or `FS_DEF` cycles when `fs_width` is 0. No FIFO read starts while it is high.
- R7: Each FIFO read is a `fifo_rd` pulse of `rd_width` cycles, or `RD_DEF` cycles when `rd_width` is 0. A read starts only when `fifo_empty` is low. `dn_strobe` equals `fifo_rd` for forwarded words and stays low for dropped words, with `dn_data` held for the whole pulse.
- R8: Inside a frame, if `TO_CYC` cycles pass without a read starting (frame-start time excluded), the block sets `status[5]` and `status[3]`, pulses `frame_irq` and returns to hunting while staying active.
- R9: `abort` stops all further reads until the next `start`. If it arrives inside a frame it sets `status[4]` and `status[3]`. If it arrives while hunting it sets neither.
- R10: `status[0]` is 1 while active and hunting. `status[6]` is 1 while inside a frame. Bits 1, 3, 4 and 5 are sticky and are cleared when the next sync pair is found. Bits 2, 7 and 8 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse: begin continuous readout |
| abort | input | 1 | One-cycle pulse: stop readout |
| use_rc | input | 1 | 1: pixel count from header rows × cols; 0: use pix_n |
| pix_n | input | CNT_W | Programmed pixel count |
| fs_width | input | FSW_W | Frame-start pulse width in cycles, 0 selects FS_DEF |
| rd_width | input | RDW_W | Read/strobe pulse width in cycles, 0 selects RD_DEF |
| fifo_empty | input | 1 | FIFO has no data |
| fifo_data | input | DW | Head-of-FIFO word, valid when not empty |
| fifo_rd | output | 1 | FIFO read pulse; FIFO advances when it falls |
| dn_data | output | DW | Word to the downstream processor |
| dn_strobe | output | 1 | Downstream strobe, the read pulse of forwarded words |
| frame_start | output | 1 | Frame-start pulse |
| frame_irq | output | 1 | One-cycle end-of-frame-attempt pulse |
| status | output | 9 | Frame status word |

## Verification
The assertions assume a first-word-fall-through FIFO. Its head word must stay stable while `fifo_empty` is low, and it may advance only after `fifo_rd` falls. The bench FIFO model pops on the falling edge of the read pulse and changes data and the empty flag only there or when it is loaded. `start` and `abort` are assumed to be single-cycle pulses, and the bench drives them that way. Frames are loaded into the model FIFO in full, so that reads inside a frame never stall, except in the timeout case, which loads a deliberately truncated frame.

// File: rtl/camfr_pkg.sv
package camfr_pkg;
  typedef enum logic [1:0] {S_HUNT, S_HDR, S_PIX, S_EOF} rf_state_e;

  localparam int ST_W     = 9;
  // status bit positions (host software decodes these)
  localparam int B_HUNT   = 0;
  localparam int B_EOFERR = 1;
  localparam int B_BUFOK  = 2;
  localparam int B_LAST   = 3;
  localparam int B_ABORT  = 4;
  localparam int B_TMO    = 5;
  localparam int B_BUSY   = 6;
  localparam int B_BUFWT  = 7;
  localparam int B_HFTMO  = 8;

  // index of header words counted from the first word after the sync pair
  localparam int HIDX_W   = 3;
  localparam int HDR_ROWS = 6;
  localparam int HDR_COLS = 7;
endpackage

// File: rtl/rf_pulse.sv
module rf_pulse #(
  parameter int CW  = 8,
  parameter int DEF = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [CW-1:0] width,
  output logic          busy
);
  localparam logic [CW-1:0] DEF_V = CW'(DEF);

  logic [CW-1:0] cnt;
  logic [CW-1:0] eff;

  assign eff = (width == '0) ? DEF_V : width;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (fire) begin
      busy <= 1'b1;
      cnt  <= eff - 1'b1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // R6 and R7: a pulse with cycles remaining stays high
  assert_pulse_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != '0) |=> busy);
  // R6 and R7: a pulse only begins on a fire request
  assert_pulse_origin_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(fire));
endmodule

// File: rtl/rf_timeout.sv
module rf_timeout #(
  parameter int LIMIT = 1625000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic reload,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || reload || !arm) cnt <= '0;
    else if (cnt != LIM_V)     cnt <= cnt + 1'b1;
  end

  assign hit = arm && (cnt == LIM_V);

  // R8: counting stops when the limit is reached
  assert_to_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM_V);
endmodule

// File: rtl/cam_frame_reformat.sv
module cam_frame_reformat import camfr_pkg::*; #(
  parameter int DW     = 16,
  parameter int CNT_W  = 32,
  parameter int FSW_W  = 16,
  parameter int RDW_W  = 8,
  parameter int FS_DEF = 2000,
  parameter int RD_DEF = 5,
  parameter int TO_CYC = 1625000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             abort,
  input  logic             use_rc,
  input  logic [CNT_W-1:0] pix_n,
  input  logic [FSW_W-1:0] fs_width,
  input  logic [RDW_W-1:0] rd_width,
  input  logic             fifo_empty,
  input  logic [DW-1:0]    fifo_data,
  output logic             fifo_rd,
  output logic [DW-1:0]    dn_data,
  output logic             dn_strobe,
  output logic             frame_start,
  output logic             frame_irq,
  output logic [ST_W-1:0]  status
);
  localparam logic [HIDX_W-1:0] IDX_ROWS = HIDX_W'(HDR_ROWS);
  localparam logic [HIDX_W-1:0] IDX_COLS = HIDX_W'(HDR_COLS);

  rf_state_e         st;
  logic              active, prev_zero, fwd_q;
  logic              err_eof, last_q, abrt_q, tmo_q;
  logic [HIDX_W-1:0] hidx;
  logic [DW-1:0]     rows_q;
  logic [CNT_W-1:0]  left;
  logic              rd_busy, fs_busy, to_hit, to_arm;
  logic              go, w_zero, sync_hit, fwd_now;
  logic [2*DW-1:0]   rc_prod;
  logic [CNT_W-1:0]  npix;

  assign w_zero   = (fifo_data == '0);
  assign go       = active && !fifo_empty && !rd_busy && !fs_busy && !abort && !to_hit;
  assign sync_hit = go && (st == S_HUNT) && w_zero && prev_zero;
  assign fwd_now  = ((st == S_HDR) && (hidx != '0)) || (st == S_PIX);
  assign rc_prod  = rows_q * fifo_data;
  assign npix     = use_rc ? CNT_W'(rc_prod) : pix_n;
  assign to_arm   = active && (st != S_HUNT) && !fs_busy;

  rf_pulse #(.CW(RDW_W), .DEF(RD_DEF)) u_rd_pulse (
    .clk(clk), .rst(rst), .fire(go), .width(rd_width), .busy(rd_busy));

  rf_pulse #(.CW(FSW_W), .DEF(FS_DEF)) u_fs_pulse (
    .clk(clk), .rst(rst), .fire(sync_hit), .width(fs_width), .busy(fs_busy));

  rf_timeout #(.LIMIT(TO_CYC)) u_timeout (
    .clk(clk), .rst(rst), .arm(to_arm), .reload(go), .hit(to_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_HUNT;
      active    <= 1'b0;
      prev_zero <= 1'b0;
      fwd_q     <= 1'b0;
      err_eof   <= 1'b0;
      last_q    <= 1'b0;
      abrt_q    <= 1'b0;
      tmo_q     <= 1'b0;
      hidx      <= '0;
      rows_q    <= '0;
      left      <= '0;
      dn_data   <= '0;
      frame_irq <= 1'b0;
    end else begin
      frame_irq <= 1'b0;
      if (start && !active) begin
        active    <= 1'b1;
        st        <= S_HUNT;
        prev_zero <= 1'b0;
      end
      if (abort) begin
        active    <= 1'b0;
        st        <= S_HUNT;
        prev_zero <= 1'b0;
        if (st != S_HUNT) begin
          abrt_q <= 1'b1;
          last_q <= 1'b1;
        end
      end else if (to_hit) begin
        st        <= S_HUNT;
        prev_zero <= 1'b0;
        tmo_q     <= 1'b1;
        last_q    <= 1'b1;
        frame_irq <= 1'b1;
      end else if (go) begin
        fwd_q <= fwd_now;
        if (fwd_now) dn_data <= fifo_data;
        unique case (st)
          S_HUNT: begin
            if (w_zero && prev_zero) begin
              st        <= S_HDR;
              hidx      <= '0;
              prev_zero <= 1'b0;
              err_eof   <= 1'b0;
              last_q    <= 1'b0;
              abrt_q    <= 1'b0;
              tmo_q     <= 1'b0;
            end else begin
              prev_zero <= w_zero;
            end
          end
          S_HDR: begin
            hidx <= hidx + 1'b1;
            if (hidx == IDX_ROWS) rows_q <= fifo_data;
            if (hidx == IDX_COLS) begin
              left <= npix;
              st   <= (npix == '0) ? S_EOF : S_PIX;
            end
          end
          S_PIX: begin
            left <= left - 1'b1;
            if (left == CNT_W'(1)) st <= S_EOF;
          end
          S_EOF: begin
            st        <= S_HUNT;
            frame_irq <= 1'b1;
            if (!w_zero) err_eof <= 1'b1;
          end
          default: st <= S_HUNT;
        endcase
      end
    end
  end

  assign fifo_rd     = rd_busy;
  assign dn_strobe   = rd_busy && fwd_q;
  assign frame_start = fs_busy;

  always_comb begin
    status           = '0;
    status[B_HUNT]   = active && (st == S_HUNT);
    status[B_EOFERR] = err_eof;
    status[B_LAST]   = last_q;
    status[B_ABORT]  = abrt_q;
    status[B_TMO]    = tmo_q;
    status[B_BUSY]   = (st != S_HUNT);
  end

  assert_rd_needs_data_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(fifo_rd) |-> $past(!fifo_empty));
  assert_dn_data_held_R7: assert property (@(posedge clk) disable iff (rst)
    (dn_strobe && $past(dn_strobe)) |-> $stable(dn_data));
  assert_no_read_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(fifo_rd) |-> $past(active));
  assert_fs_at_sync_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_start) |-> (st == S_HDR));
  assert_hunt_busy_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({status[B_HUNT], status[B_BUSY]}));
  assert_irq_single_R5: assert property (@(posedge clk) disable iff (rst)
    frame_irq |=> !frame_irq);
  assert_to_leaves_frame_R8: assert property (@(posedge clk) disable iff (rst)
    to_hit |=> !to_hit);
endmodule

// File: tb/tb_cam_frame_reformat.sv
module tb_cam_frame_reformat;
  localparam int CLK_PERIOD = 10;
  localparam int FSD = 6;
  localparam int RDD = 2;
  localparam int TOC = 40;
  localparam int QN  = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, abort = 1'b0, use_rc = 1'b1;
  logic [31:0] pix_n = '0;
  logic [15:0] fs_width = '0;
  logic [7:0]  rd_width = '0;
  logic        fifo_empty;
  logic [15:0] fifo_data;
  logic        fifo_rd, dn_strobe, frame_start, frame_irq;
  logic [15:0] dn_data;
  logic [8:0]  status;

  logic [15:0] fq [0:QN-1];
  int wp = 0, rp = 0;
  assign fifo_empty = (wp == rp);
  assign fifo_data  = fq[rp % QN];

  cam_frame_reformat #(.FS_DEF(FSD), .RD_DEF(RDD), .TO_CYC(TOC)) dut (
    .clk(clk), .rst(rst), .start(start), .abort(abort), .use_rc(use_rc),
    .pix_n(pix_n), .fs_width(fs_width), .rd_width(rd_width),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
    .dn_data(dn_data), .dn_strobe(dn_strobe), .frame_start(frame_start),
    .frame_irq(frame_irq), .status(status));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nerr = 0;
  int exp_rdw = RDD;
  int rd_run = 0, rd_bad = 0, underflow = 0, dn_bad = 0;
  int fs_run = 0, fs_last = 0, fs_cnt = 0, irq_cnt = 0, ncap = 0;
  logic prev_rd = 1'b0, prev_dn = 1'b0, prev_fs = 1'b0;
  logic [15:0] cap [0:255];

  always @(negedge clk) begin
    if (fifo_rd) rd_run = prev_rd ? rd_run + 1 : 1;
    else if (prev_rd) begin
      if (rp == wp) underflow++; else rp++;
      if (rd_run != exp_rdw) rd_bad++;
      rd_run = 0;
    end
    if (dn_strobe && !prev_dn) begin
      if (ncap < 256) cap[ncap] = dn_data;
      ncap++;
    end
    if (dn_strobe && !fifo_rd) dn_bad++;
    if (frame_start) fs_run = prev_fs ? fs_run + 1 : 1;
    else if (prev_fs) begin fs_last = fs_run; fs_cnt++; end
    if (frame_irq) irq_cnt++;
    prev_rd = fifo_rd; prev_dn = dn_strobe; prev_fs = frame_start;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] w);
    fq[wp % QN] = w;
    wp++;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic pulse_abort();
    @(negedge clk) abort = 1'b1;
    @(negedge clk) abort = 1'b0;
  endtask

  task automatic run_frame(input int rows, input int cols, input bit rc, input int pn,
                           input int rdw, input int fsw, input bit eofz, input int base);
    int npix, irq0, fs0, exp_fs;
    logic [15:0] exp_w [0:63];
    @(negedge clk);
    use_rc = rc; pix_n = 32'(pn); rd_width = 8'(rdw); fs_width = 16'(fsw);
    exp_rdw = (rdw == 0) ? RDD : rdw;
    exp_fs  = (fsw == 0) ? FSD : fsw;
    npix = rc ? rows * cols : pn;
    ncap = 0; irq0 = irq_cnt; fs0 = fs_cnt; rd_bad = 0; dn_bad = 0; underflow = 0;
    exp_w[0] = 16'(base + 1);  exp_w[1] = 16'(base + 2);  exp_w[2] = 16'(base + 3);
    exp_w[3] = 16'(base + 4);  exp_w[4] = 16'(base + 5);
    exp_w[5] = 16'(rows);      exp_w[6] = 16'(cols);
    for (int i = 0; i < npix; i++) exp_w[7+i] = 16'(base * 7 + i * 3 + 1);
    // garbage with a lone zero (R2), then sync pair, duplicated mode word
    push(16'h0005); push(16'h0000); push(16'h0007);
    push(16'h0000); push(16'h0000);
    push(16'h00EE);
    for (int i = 0; i < 7 + npix; i++) push(exp_w[i]);
    push(eofz ? 16'h0000 : 16'hBEEF);
    repeat ((npix + 20) * (exp_rdw + 2) + exp_fs + 30) @(negedge clk);
    chk("R4 forwarded word count", ncap, 7 + npix);
    for (int i = 0; i < 7 + npix && i < ncap; i++)
      chk(i < 7 ? "R3 header word" : "R3 pixel word", cap[i], exp_w[i]);
    chk("R5 one irq per frame", irq_cnt - irq0, 1);
    chk("R5 eof error bit", status[1], eofz ? 0 : 1);
    chk("R6 one frame start", fs_cnt - fs0, 1);
    chk("R6 frame start width", fs_last, exp_fs);
    chk("R7 read width errors", rd_bad, 0);
    chk("R7 strobe outside read", dn_bad, 0);
    chk("R7 read while empty", underflow, 0);
    chk("R10 hunting after frame", {status[6], status[0]}, 2'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int rsave, k;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 reset outputs", {fifo_rd, dn_strobe, frame_start, frame_irq}, 0);
    chk("R1 reset status", status, 0);
    rst = 1'b0;
    push(16'h0000); push(16'h0000); // data present but not started
    repeat (10) @(negedge clk);
    chk("R1 idle no reads", rp, 0);
    chk("R10 idle status", status, 0);
    rp = wp;
    pulse_start();
    @(negedge clk);
    chk("R10 hunting bit", status, 9'h001);

    // sweep over header-derived counts
    k = 0;
    for (int r = 0; r < 4; r++)
      for (int c = 1; c < 4; c++) begin
        run_frame(r, c, 1'b1, 99, (k % 3 == 0) ? 0 : (k % 3 == 1 ? 1 : 3),
                  (k % 2) ? 3 : 0, ((r + c) % 5) != 0, 16 * k + 32);
        k++;
      end
    // programmed pixel count, header rows*cols ignored
    for (int p = 0; p < 5; p++)
      run_frame(2, 3, 1'b0, p, 1, 2, 1'b1, 500 + 16 * p);

    // R8 timeout on a truncated frame
    @(negedge clk);
    k = irq_cnt;
    push(16'h0000); push(16'h0000); push(16'h0011); push(16'h0011); push(16'h0022);
    repeat (120) @(negedge clk);
    chk("R8 timeout irq", irq_cnt - k, 1);
    chk("R8 timeout bits", {status[5], status[3]}, 2'b11);
    chk("R8 still active hunting", {status[6], status[0]}, 2'b01);
    run_frame(1, 2, 1'b1, 0, 0, 0, 1'b1, 900);
    chk("R10 sticky cleared at sync", {status[5], status[3]}, 2'b00);

    // R9 abort inside a frame
    run_frame(0, 1, 1'b1, 0, 0, 0, 1'b1, 950);
    @(negedge clk);
    rd_width = 8'd3; exp_rdw = 3; use_rc = 1'b0; pix_n = 32'd40;
    push(16'h0000); push(16'h0000);
    for (int i = 0; i < 50; i++) push(16'(i + 1));
    repeat (40) @(negedge clk);
    pulse_abort();
    repeat (10) @(negedge clk);
    rsave = rp;
    repeat (60) @(negedge clk);
    chk("R9 no reads after abort", rp, rsave);
    chk("R9 abort bits", {status[4], status[3]}, 2'b11);
    chk("R9 inactive status", {status[6], status[0]}, 2'b00);
    rp = wp;
    pulse_start();
    @(negedge clk);
    chk("R10 abort bit sticky until sync", status[4], 1);
    run_frame(2, 2, 1'b1, 0, 2, 0, 1'b1, 1200);
    chk("R10 abort bit cleared", status[4], 0);
    chk("R10 reserved bits zero", {status[8], status[7], status[2]}, 0);

    // R9 abort while hunting
    pulse_abort();
    @(negedge clk);
    chk("R9 abort while hunting", status, 0);
    pulse_start();
    run_frame(1, 1, 1'b1, 0, 0, 0, 1'b1, 1300);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule